// File: doc/BRIEF.md
# Tagged Receive Byte FIFO

This block is the receive-side byte queue of a serial packet controller. A deframer upstream pushes each recovered byte into it together with a 2-bit tag. The tag marks the byte as the first of a packet, a middle byte, or the last byte with a good or a bad frame check. A processor-side port pops bytes in arrival order. The tag of the byte at the head of the queue is always visible, so software knows what its next read will return. It can therefore drain a packet exactly up to its closing byte.

The queue holds 19 entries, a depth that is not a power of two, so the pointers wrap modulo 19 and an explicit fill count runs from 0 to 19. The empty flag and the fill level are presented late, a set number of ticks after the state changes, to model a status path that lags each access. Two level interrupts are derived from this delayed status, each with its own mask input. The fill interrupt asserts at 15 entries. The end-of-packet interrupt asserts while a last-byte entry is stored. A write to a full queue is dropped and sets a sticky overflow flag.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset, st_empty is 1, st_level is 0, both interrupts are 0, ovf is 0, rd_data is 0 and head_tag is 0.
- R2: Bytes are returned in the order they were written. rd_data takes the popped byte on the clock edge that accepts the read and holds it until the next accepted read.
- R3: Tags are encoded 0 = first, 1 = middle, 2 = last with good check, 3 = last with bad check. head_tag shows the tag of the entry the next read returns, from the edge after any access, and shows 0 when the queue is empty.
- R4: The queue holds DEPTH = 19 entries. A write to a full queue without a simultaneous read is dropped and sets ovf. ovf then stays 1 until reset.
- R5: A read of an empty queue changes nothing: rd_data keeps its value and no entry is consumed.
- R6: st_empty and st_level show the fill count as it was STAT_DLY = 2 cycles earlier. A change caused at clock edge E therefore appears after edge E+2.
- R7: irq_thr is 1 when the delayed level is at least THRESH = 15 and mask_thr is 0. Otherwise it is 0. The mask acts at once.
- R8: irq_eop is 1 while the delayed status shows at least one stored entry with tag 2 or 3 and mask_eop is 0. Otherwise it is 0. The mask acts at once.
- R9: A simultaneous read and write on a full queue performs both, keeps the level at 19 and does not set ovf. A simultaneous read and write on an empty queue stores the byte and ignores the read. The pointers wrap modulo 19 with no loss of order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push request from the deframer |
| wr_data | input | 8 | Byte to push |
| wr_tag | input | 2 | Tag of the byte to push |
| rd_en | input | 1 | Pop request from the processor side |
| mask_thr | input | 1 | 1 masks the fill interrupt |
| mask_eop | input | 1 | 1 masks the end-of-packet interrupt |
| rd_data | output | 8 | Last popped byte |
| head_tag | output | 2 | Tag of the entry the next read returns |
| st_empty | output | 1 | Delayed empty flag |
| st_level | output | 5 | Delayed fill level, 0 to 19 |
| ovf | output | 1 | Sticky overflow flag |
| irq_thr | output | 1 | Fill-threshold interrupt, level |
| irq_eop | output | 1 | End-of-packet interrupt, level |

## Verification
Results fall due at three different times. rd_data, head_tag and ovf change on the edge that accepts the access. The delayed status and both interrupts change two edges later, and a mask change shows at once. The bench drives each access on a falling edge and samples at the falling edge that follows. For delayed outputs it first waits two idle cycles, or it samples at each of the three falling edges after an access to show that the value holds before it moves. The bench also keeps its own queue model and uses it to predict the byte order and the head tag.

// File: rtl/rx_tag_fifo_pkg.sv
package rx_tag_fifo_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        TAG_FIRST    = 2'd0,
        TAG_MID      = 2'd1,
        TAG_LAST_OK  = 2'd2,
        TAG_LAST_BAD = 2'd3
    } tag_e;

    typedef struct packed {
        logic [1:0]        tag;
        logic [BYTE_W-1:0] data;
    } entry_t;

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
    import rx_tag_fifo_pkg::*;
#(
    parameter int DEPTH = 19,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        wr_tag,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic [1:0]        head_tag,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  nlast,
    output logic              ovf
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0]  wr_ptr;
        logic [PTR_W-1:0]  rd_ptr;
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  nlast;
        logic              ovf;
        logic [BYTE_W-1:0] rd_data;
    } state_t;

    state_t st_q, st_d;
    entry_t mem_q [DEPTH];
    entry_t head;
    logic   do_pop, do_push;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        head    = mem_q[st_q.rd_ptr];
        do_pop  = rd_en && (st_q.count != '0);
        do_push = wr_en && ((st_q.count != FULL_CNT) || do_pop);
        st_d    = st_q;
        if (do_pop) begin
            st_d.rd_ptr  = ptr_next(st_q.rd_ptr);
            st_d.rd_data = head.data;
        end
        if (do_push) begin
            st_d.wr_ptr = ptr_next(st_q.wr_ptr);
        end
        if (wr_en && !do_push) begin
            st_d.ovf = 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
        case ({do_push && wr_tag[1], do_pop && head.tag[1]})
            2'b10:   st_d.nlast = st_q.nlast + 1'b1;
            2'b01:   st_d.nlast = st_q.nlast - 1'b1;
            default: st_d.nlast = st_q.nlast;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[st_q.wr_ptr] <= '{tag: wr_tag, data: wr_data};
        end
    end

    assign rd_data  = st_q.rd_data;
    assign head_tag = (st_q.count == '0) ? 2'd0 : head.tag;
    assign count    = st_q.count;
    assign nlast    = st_q.nlast;
    assign ovf      = st_q.ovf;

    // R4: fill count never exceeds the capacity
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= FULL_CNT);

    // R4: overflow flag is sticky
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);

    // R4: a write into a full queue without a read is dropped
    a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && st_q.count == FULL_CNT) |=> (st_q.count == FULL_CNT) && st_q.ovf);

    // R5: a read of an empty queue leaves the output byte alone
    a_r5_empty_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st_q.count == '0) |=> $stable(st_q.rd_data) && $stable(st_q.rd_ptr));

    // R9: pointers stay inside the modulo range
    a_r9_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr_ptr <= LAST_PTR) && (st_q.rd_ptr <= LAST_PTR));

endmodule

// File: rtl/rx_fifo_stat_dly.sv
module rx_fifo_stat_dly #(
    parameter int CNT_W    = 5,
    parameter int STAT_DLY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] nlast,
    output logic             st_empty,
    output logic [CNT_W-1:0] st_level,
    output logic             st_has_last
);

    typedef struct packed {
        logic             empty;
        logic [CNT_W-1:0] level;
        logic             has_last;
    } stat_t;

    localparam stat_t RST_STAT = '{empty: 1'b1, level: '0, has_last: 1'b0};

    stat_t pipe_q [STAT_DLY];
    stat_t pipe_d [STAT_DLY];

    always_comb begin
        pipe_d[0] = '{empty: (count == '0), level: count, has_last: (nlast != '0)};
        for (int i = 1; i < STAT_DLY; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAT_DLY; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe_q[g] <= RST_STAT;
                end else begin
                    pipe_q[g] <= pipe_d[g];
                end
            end
        end
    endgenerate

    assign st_empty    = pipe_q[STAT_DLY-1].empty;
    assign st_level    = pipe_q[STAT_DLY-1].level;
    assign st_has_last = pipe_q[STAT_DLY-1].has_last;

    // R6: delayed empty flag agrees with the delayed level
    a_r6_empty_level: assert property (@(posedge clk) disable iff (!rst_n)
        st_empty == (st_level == '0));

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
    parameter int DEPTH    = 19,
    parameter int THRESH   = 15,
    parameter int STAT_DLY = 2,
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [1:0]       wr_tag,
    input  logic             rd_en,
    input  logic             mask_thr,
    input  logic             mask_eop,
    output logic [7:0]       rd_data,
    output logic [1:0]       head_tag,
    output logic             st_empty,
    output logic [CNT_W-1:0] st_level,
    output logic             ovf,
    output logic             irq_thr,
    output logic             irq_eop
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] THR_CNT = CNT_W'(THRESH);

    logic [CNT_W-1:0] count, nlast;
    logic             st_has_last;

    rx_fifo_store #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_tag   (wr_tag),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .head_tag (head_tag),
        .count    (count),
        .nlast    (nlast),
        .ovf      (ovf)
    );

    rx_fifo_stat_dly #(
        .CNT_W    (CNT_W),
        .STAT_DLY (STAT_DLY)
    ) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .count       (count),
        .nlast       (nlast),
        .st_empty    (st_empty),
        .st_level    (st_level),
        .st_has_last (st_has_last)
    );

    always_comb begin
        irq_thr = (st_level >= THR_CNT) && !mask_thr;
        irq_eop = st_has_last && !mask_eop;
    end

    // R8: an end-of-packet interrupt needs a stored closing entry
    a_r8_eop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eop |-> !st_empty);

    // R7: the fill interrupt only fires with a non-empty queue
    a_r7_thr_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        irq_thr |-> !st_empty);

endmodule

// File: tb/rx_tag_fifo_tb.sv
module rx_tag_fifo_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] wr_tag = '0;
    logic       rd_en = 1'b0;
    logic       mask_thr = 1'b0;
    logic       mask_eop = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] head_tag;
    logic       st_empty;
    logic [4:0] st_level;
    logic       ovf, irq_thr, irq_eop;

    int n_checks = 0;
    int n_errors = 0;
    logic [9:0] model[$];

    always #2 clk = ~clk;

    rx_tag_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
        .rd_en(rd_en), .mask_thr(mask_thr), .mask_eop(mask_eop), .rd_data(rd_data),
        .head_tag(head_tag), .st_empty(st_empty), .st_level(st_level), .ovf(ovf),
        .irq_thr(irq_thr), .irq_eop(irq_eop)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 0; rd_en = 0; mask_thr = 0; mask_eop = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model.delete();
    endtask

    // one access cycle; returns at the falling edge after the clock edge
    task automatic step(input logic w, input logic [7:0] d, input logic [1:0] t, input logic r);
        logic popped;
        logic pushed;
        wr_en = w; wr_data = d; wr_tag = t; rd_en = r;
        popped = r && (model.size() != 0);
        pushed = w && (model.size() < 19 || popped);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        if (popped) void'(model.pop_front());
        if (pushed) model.push_back({t, d});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 st_empty", st_empty, 1);
        chk("R1 st_level", st_level, 0);
        chk("R1 irq_thr", irq_thr, 0);
        chk("R1 irq_eop", irq_eop, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 head_tag", head_tag, 0);
    endtask

    task automatic t_order_tags();
        do_reset();
        step(1, 8'hA1, 2'd0, 0);
        chk("R3 head first", head_tag, 0);
        step(1, 8'hB2, 2'd1, 0);
        step(1, 8'hC3, 2'd3, 0);
        step(1, 8'hD4, 2'd2, 0);
        chk("R3 head still first", head_tag, 0);
        step(0, 0, 0, 1);
        chk("R2 byte0", rd_data, 8'hA1);
        chk("R3 head middle", head_tag, 1);
        step(0, 0, 0, 1);
        chk("R2 byte1", rd_data, 8'hB2);
        chk("R3 head last bad", head_tag, 3);
        idle(2);
        chk("R2 rd_data held", rd_data, 8'hB2);
        step(0, 0, 0, 1);
        chk("R2 byte2", rd_data, 8'hC3);
        chk("R3 head last good", head_tag, 2);
        step(0, 0, 0, 1);
        chk("R2 byte3", rd_data, 8'hD4);
        chk("R3 head empty", head_tag, 0);
    endtask

    task automatic t_empty_read();
        do_reset();
        step(1, 8'h5A, 2'd1, 0);
        step(0, 0, 0, 1);
        chk("R5 first read", rd_data, 8'h5A);
        step(0, 0, 0, 1);
        chk("R5 empty read keeps byte", rd_data, 8'h5A);
        idle(2);
        chk("R5 level stays 0", st_level, 0);
        step(1, 8'h6B, 2'd0, 1);
        chk("R9 empty rd+wr keeps byte", rd_data, 8'h5A);
        idle(2);
        chk("R9 empty rd+wr stores", st_level, 1);
        step(0, 0, 0, 1);
        chk("R5 next byte after empty read", rd_data, 8'h6B);
    endtask

    task automatic t_status_delay();
        do_reset();
        step(1, 8'h11, 2'd0, 0);
        chk("R6 edge+0 empty", st_empty, 1);
        idle(1);
        chk("R6 edge+1 empty", st_empty, 1);
        idle(1);
        chk("R6 edge+2 not empty", st_empty, 0);
        chk("R6 edge+2 level", st_level, 1);
        step(0, 0, 0, 1);
        idle(1);
        chk("R6 read edge+1 level", st_level, 1);
        idle(1);
        chk("R6 read edge+2 level", st_level, 0);
    endtask

    task automatic t_full_ovf();
        do_reset();
        for (int i = 0; i < 19; i++) step(1, 8'(8'h20 + i), 2'd1, 0);
        idle(2);
        chk("R4 level 19", st_level, 19);
        chk("R4 no ovf at 19", ovf, 0);
        step(1, 8'hEE, 2'd1, 0);
        chk("R4 ovf set", ovf, 1);
        idle(2);
        chk("R4 level stays 19", st_level, 19);
        for (int i = 0; i < 19; i++) begin
            step(0, 0, 0, 1);
            chk("R4 drain order", rd_data, 8'h20 + i);
        end
        idle(2);
        chk("R4 dropped byte absent", st_empty, 1);
        chk("R4 ovf sticky", ovf, 1);
        do_reset();
        chk("R4 ovf cleared by reset", ovf, 0);
    endtask

    task automatic t_simul_wrap();
        logic [9:0] e;
        do_reset();
        for (int i = 0; i < 19; i++) step(1, 8'(i), 2'd1, 0);
        for (int i = 0; i < 25; i++) begin
            e = model[0];
            step(1, 8'(8'h80 + i), 2'd1, 1);
            chk("R9 full rd+wr byte", rd_data, e[7:0]);
        end
        idle(2);
        chk("R9 level after rd+wr", st_level, 19);
        chk("R9 no ovf", ovf, 0);
        for (int i = 0; i < 19; i++) begin
            e = model[0];
            step(0, 0, 0, 1);
            chk("R9 wrapped order", rd_data, e[7:0]);
        end
    endtask

    task automatic t_thresh();
        do_reset();
        for (int i = 0; i < 14; i++) step(1, 8'(i), 2'd1, 0);
        idle(2);
        chk("R7 below threshold", irq_thr, 0);
        step(1, 8'h0E, 2'd1, 0);
        idle(1);
        chk("R7 not yet", irq_thr, 0);
        idle(1);
        chk("R7 at 15", irq_thr, 1);
        mask_thr = 1'b1;
        #1;
        chk("R7 masked", irq_thr, 0);
        mask_thr = 1'b0;
        #1;
        chk("R7 unmasked", irq_thr, 1);
        @(negedge clk);
        step(0, 0, 0, 1);
        idle(2);
        chk("R7 back to 14", irq_thr, 0);
    endtask

    task automatic t_eop();
        do_reset();
        step(1, 8'h01, 2'd0, 0);
        step(1, 8'h02, 2'd1, 0);
        idle(3);
        chk("R8 no last stored", irq_eop, 0);
        step(1, 8'h03, 2'd2, 0);
        idle(1);
        chk("R8 not yet", irq_eop, 0);
        idle(1);
        chk("R8 raised", irq_eop, 1);
        mask_eop = 1'b1;
        #1;
        chk("R8 masked", irq_eop, 0);
        mask_eop = 1'b0;
        @(negedge clk);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        idle(2);
        chk("R8 held before last read", irq_eop, 1);
        chk("R3 head is closing tag", head_tag, 2);
        step(0, 0, 0, 1);
        idle(2);
        chk("R8 cleared after drain", irq_eop, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_order_tags();
        t_empty_read();
        t_status_delay();
        t_full_ovf();
        t_simul_wrap();
        t_thresh();
        t_eop();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule